// File: doc/BRIEF.md
# Timer Compare Unit

This unit watches a free-running 64-bit time value from an external counter. It compares that value against a set of programmable 64-bit compare values, one for each channel. When an enabled channel sees the time equal its compare value, the unit raises a one-cycle match pulse for that channel and sets a sticky status flag. Software clears the flag by writing a one to it. An interrupt request stays high while any flag of an enabled channel is set.

Channel 0 can also ask the counter to return to zero, which turns the time value into a repeating cycle. To make the cycle length P with a counter that advances by INC each tick, channel 0 is loaded with P − INC. The clear request is combinational from the time input, so the counter reloads zero on the same edge at which it would otherwise have passed the compare value. In shadow mode, writes to the compare registers land in a holding copy. That copy moves into the live compare value only at the instant of a counter clear, so a cycle is never cut by a half-updated 64-bit value.

Software reaches the unit through a plain word-addressed write strobe and a combinational read port. The time input and the match, clear and interrupt outputs are plain level signals with no handshake. The unit cannot stall them, and nothing in it applies back-pressure.

Top module: `timer_compare_unit`

## Requirements
- R1: After reset the configuration word, the status word and every compare value read as zero, and match_o, cnt_clr_o and irq_o are low.
- R2: Word address 0 holds the configuration: bit 0 requests a counter clear on a channel 0 match, bit n+1 enables channel n (bits 1 to NUM_CH), and bit NUM_CH+1 selects shadow mode. Address 1 holds the status word, with bit n belonging to channel n. Compare value n has its low 32 bits at address 2+2n and its high 32 bits at address 3+2n. All of these read back through rd_data_o, and a compare address returns the live compare value.
- R3: When an enabled channel sees cnt_i equal to its full 64-bit compare value on a clock edge, match_o bit n is high for exactly the following cycle. A channel whose time input stays equal produces no further pulse until the time has differed for at least one edge.
- R4: A channel whose enable bit is clear never pulses and never sets its status bit, even while cnt_i equals its compare value.
- R5: A status bit is set by its channel's match and then holds. Writing 1 to it at address 1 clears it. Writing 0 leaves it unchanged, and writing 1 to a bit that is already clear has no effect.
- R6: irq_o is high exactly while some channel has both its status bit and its enable bit set. Clearing the enable masks the request without clearing the status bit.
- R7: cnt_clr_o is high in the same cycle as cnt_i first equals compare value 0, provided channel 0 is enabled and configuration bit 0 is set. It is never high while bit 0 is clear.
- R8: With shadow mode off, a compare write changes the live compare value at once. The next cycle's readback and matching use the new value.
- R9: With shadow mode on, compare writes leave the live value and its readback untouched. The written value becomes live on the edge at which cnt_clr_o is high.
- R10: With configuration bit 0 set, compare value 0 = P − INC, and a counter that advances by INC per cycle and reloads zero on cnt_clr_o, cnt_clr_o pulses every P/INC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CNT_W | Current time value from the counter |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Write word address |
| wdata_i | input | REG_W | Write data |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_data_o | output | REG_W | Read data, combinational from rd_addr_i |
| match_o | output | NUM_CH | One-cycle match pulse per channel |
| cnt_clr_o | output | 1 | Request to reload the counter with zero |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties assume that the time input and the write port only change between clock edges. They also assume a configuration that enables shadow mode does not change the compare values of disabled channels in ways the properties track. Beyond that, they rely only on the unit's own registers. The bench changes every input at the falling edge and samples at the falling edge. It holds the time value at a value that no vector uses while it reprograms the unit, so every match it sees comes from one deliberate step of cnt_i. In the cyclic test the counter model moves only on rising edges and reacts to cnt_clr_o, the way the real counter would.

// File: rtl/tcu_pkg.sv
`timescale 1ns/1ps
package tcu_pkg;
  // Fixed word offsets of the register file
  localparam int unsigned CFG_ADDR  = 0;
  localparam int unsigned STAT_ADDR = 1;
  localparam int unsigned CMP_BASE  = 2;
  // Configuration bit that arms the counter clear from channel 0
  localparam int unsigned CFG_CLR_BIT = 0;
  localparam int unsigned CFG_EN_LSB  = 1;

  typedef enum logic [2:0] {
    REG_CFG,
    REG_STAT,
    REG_CMP_LO,
    REG_CMP_HI,
    REG_NONE
  } reg_kind_e;
endpackage

// File: rtl/tcu_channel.sv
`timescale 1ns/1ps
module tcu_channel #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             en_i,
  input  logic             shadow_i,
  input  logic             load_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [CNT_W-1:0] active_o,
  output logic             hit_o,
  output logic             match_o
);
  localparam int unsigned HI_W = CNT_W - REG_W;

  logic [CNT_W-1:0] hold_q;
  logic [CNT_W-1:0] live_q;
  logic             eq_seen_q;
  logic             pulse_q;
  logic             eq_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      if (wr_lo_i) hold_q[REG_W-1:0] <= wdata_i;
      if (wr_hi_i) hold_q[CNT_W-1:REG_W] <= wdata_i[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (!shadow_i) begin
      if (wr_lo_i) live_q[REG_W-1:0] <= wdata_i;
      if (wr_hi_i) live_q[CNT_W-1:REG_W] <= wdata_i[HI_W-1:0];
    end else if (load_i) begin
      live_q <= hold_q;
    end
  end

  assign eq_now = en_i && (cnt_i == live_q);
  assign hit_o  = eq_now && !eq_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eq_seen_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      eq_seen_q <= eq_now;
      pulse_q   <= hit_o;
    end
  end

  assign active_o = live_q;
  assign match_o  = pulse_q;

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> !match_o); // R3
  AST_MATCH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(en_i)); // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_i && !load_i) |=> $stable(live_q)); // R9
endmodule

// File: rtl/tcu_status.sv
`timescale 1ns/1ps
module tcu_status #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic [NUM_CH-1:0] status_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] flag_q;

  // A new match wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign status_o = flag_q;
  assign irq_o    = |(flag_q & en_i);

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(flag_q & ~clr_i)) == $past(flag_q & ~clr_i))); // R5
endmodule

// File: rtl/timer_compare_unit.sv
`timescale 1ns/1ps
module timer_compare_unit
  import tcu_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = $clog2(2 + 2 * NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic [NUM_CH-1:0] match_o,
  output logic              cnt_clr_o,
  output logic              irq_o
);
  localparam int unsigned N_REGS     = CMP_BASE + 2 * NUM_CH;
  localparam int unsigned CFG_W      = NUM_CH + 2;
  localparam int unsigned SHADOW_BIT = NUM_CH + 1;
  localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [CFG_W-1:0]  cfg_q;
  logic [NUM_CH-1:0] ch_en;
  logic              shadow_on;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] status;
  logic [NUM_CH-1:0] stat_clr;
  logic [CNT_W-1:0]  live [NUM_CH];

  reg_kind_e         wr_kind, rd_kind;
  logic [CH_W-1:0]   wr_ch, rd_ch;

  function automatic reg_kind_e decode(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - ADDR_W'(CMP_BASE);
    if ({1'b0, a} >= (ADDR_W+1)'(N_REGS)) return REG_NONE;
    if (a == ADDR_W'(CFG_ADDR))           return REG_CFG;
    if (a == ADDR_W'(STAT_ADDR))          return REG_STAT;
    return off[0] ? REG_CMP_HI : REG_CMP_LO;
  endfunction

  function automatic logic [CH_W-1:0] chan_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - ADDR_W'(CMP_BASE);
    return off[CH_W:1];
  endfunction

  assign wr_kind = decode(addr_i);
  assign rd_kind = decode(rd_addr_i);
  assign wr_ch   = chan_of(addr_i);
  assign rd_ch   = chan_of(rd_addr_i);

  // Configuration word
  always_ff @(posedge clk) begin
    if (!rst_n)                              cfg_q <= '0;
    else if (wr_en_i && wr_kind == REG_CFG)  cfg_q <= wdata_i[CFG_W-1:0];
  end

  assign ch_en     = cfg_q[CFG_EN_LSB +: NUM_CH];
  assign shadow_on = cfg_q[SHADOW_BIT];
  assign cnt_clr_o = hit[0] && cfg_q[CFG_CLR_BIT];
  assign stat_clr  = (wr_en_i && wr_kind == REG_STAT) ? wdata_i[NUM_CH-1:0] : '0;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic wr_lo, wr_hi;
    assign wr_lo = wr_en_i && (wr_kind == REG_CMP_LO) && (wr_ch == CH_W'(n));
    assign wr_hi = wr_en_i && (wr_kind == REG_CMP_HI) && (wr_ch == CH_W'(n));

    tcu_channel #(.CNT_W(CNT_W), .REG_W(REG_W)) i_channel (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_i    (cnt_i),
      .en_i     (ch_en[n]),
      .shadow_i (shadow_on),
      .load_i   (cnt_clr_o),
      .wr_lo_i  (wr_lo),
      .wr_hi_i  (wr_hi),
      .wdata_i  (wdata_i),
      .active_o (live[n]),
      .hit_o    (hit[n]),
      .match_o  (match_o[n])
    );
  end

  tcu_status #(.NUM_CH(NUM_CH)) i_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (hit),
    .clr_i    (stat_clr),
    .en_i     (ch_en),
    .status_o (status),
    .irq_o    (irq_o)
  );

  // Read port
  always_comb begin
    unique case (rd_kind)
      REG_CFG:    rd_data_o = REG_W'(cfg_q);
      REG_STAT:   rd_data_o = REG_W'(status);
      REG_CMP_LO: rd_data_o = live[rd_ch][REG_W-1:0];
      REG_CMP_HI: rd_data_o = REG_W'(live[rd_ch][CNT_W-1:REG_W]);
      default:    rd_data_o = '0;
    endcase
  end

  AST_CLR_FOLLOWED_BY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_o |=> (match_o[0] && status[0])); // R7
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(hit) != '0 || $past(ch_en) != ch_en)); // R6
endmodule

// File: tb/test_timer_compare_unit.sv
`timescale 1ns/1ps
module test_timer_compare_unit;
  localparam int NUM_CH = 16;
  localparam int ADDR_W = 6;
  localparam logic [31:0] SHADOW = 32'h1 << (NUM_CH + 1);

  typedef struct packed {
    logic [3:0]  ch;
    logic [63:0] cmp;
    logic [63:0] cnt;
    logic        hit;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{4'd0,  64'h0000_0001_0000_0005, 64'h0000_0001_0000_0005, 1'b1},
    '{4'd3,  64'h0000_0002_1234_5678, 64'h0000_0003_1234_5678, 1'b0},
    '{4'd15, 64'hDEAD_BEEF_0BAD_F00D, 64'hDEAD_BEEF_0BAD_F00D, 1'b1},
    '{4'd7,  64'h0000_0000_0000_0100, 64'h0000_0000_0000_0101, 1'b0},
    '{4'd9,  64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1},
    '{4'd1,  64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b1},
    '{4'd12, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0000, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [63:0]       cnt_drv = '1;
  logic [63:0]       cnt_run = '0;
  logic              run = 1'b0;
  logic [63:0]       cnt_i;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [31:0]       rd_data;
  logic [NUM_CH-1:0] match_o;
  logic              cnt_clr_o;
  logic              irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  assign cnt_i = run ? cnt_run : cnt_drv;

  always @(posedge clk) begin
    if (!run)           cnt_run <= '0;
    else if (cnt_clr_o) cnt_run <= '0;
    else                cnt_run <= cnt_run + 64'd4;
  end

  timer_compare_unit i_timer_compare_unit (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .match_o(match_o), .cnt_clr_o(cnt_clr_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_addr = ADDR_W'(a);
    #0.5;
    d = rd_data;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 match", 64'(match_o), 64'h0);
    chk("R1 clr", 64'(cnt_clr_o), 64'h0);
    chk("R1 irq", 64'(irq_o), 64'h0);
    rd(0, d);  chk("R1 cfg", 64'(d), 64'h0);
    rd(1, d);  chk("R1 status", 64'(d), 64'h0);
    rd(13, d); chk("R1 cmp5 hi", 64'(d), 64'h0);

    // R2: register map readback
    wr(0, 32'h0003_FFFF);
    rd(0, d);  chk("R2 cfg", 64'(d), 64'h3FFFF);
    wr(0, 32'h0);
    wr(11, 32'hA5A5_0004);
    rd(11, d); chk("R2 cmp4 hi", 64'(d), 64'hA5A5_0004);
    rd(10, d); chk("R2 cmp4 lo", 64'(d), 64'h0);

    // Table: R3 match, R8 immediate writes, R7 no clear while bit 0 is off
    for (int i = 0; i < 7; i++) begin
      cnt_drv = '1;
      wr(2 + 2 * VECS[i].ch, VECS[i].cmp[31:0]);
      wr(3 + 2 * VECS[i].ch, VECS[i].cmp[63:32]);
      rd(2 + 2 * VECS[i].ch, d);
      chk("R8 readback", 64'(d), 64'(VECS[i].cmp[31:0]));
      wr(0, 32'h1 << (VECS[i].ch + 1));
      wr(1, 32'hFFFF_FFFF);
      cnt_drv = VECS[i].cnt;
      #0.5;
      chk("R7 no clear", 64'(cnt_clr_o), 64'h0);
      @(negedge clk);
      chk("R3 pulse", 64'(match_o), VECS[i].hit ? (64'h1 << VECS[i].ch) : 64'h0);
      chk("R6 irq", 64'(irq_o), 64'(VECS[i].hit));
      @(negedge clk);
      chk("R3 single", 64'(match_o), 64'h0);
      rd(1, d);
      chk("R5 status", 64'(d), VECS[i].hit ? (64'h1 << VECS[i].ch) : 64'h0);
    end

    // R4: disabled channel ignores an equal time
    cnt_drv = '1;
    wr(1, 32'hFFFF_FFFF);
    wr(6, 32'h20); wr(7, 32'h0);
    wr(0, 32'h1 << 6);
    cnt_drv = 64'h20;
    @(negedge clk);
    @(negedge clk);
    chk("R4 no match", 64'(match_o), 64'h0);
    rd(1, d); chk("R4 no status", 64'(d), 64'h0);

    // R5 / R6: sticky flag, masking, write-one-clear
    cnt_drv = '1;
    wr(0, 32'h1 << 3);
    cnt_drv = 64'h20;
    @(negedge clk);
    chk("R6 irq on", 64'(irq_o), 64'h1);
    wr(1, 32'h0);
    rd(1, d); chk("R5 write zero", 64'(d), 64'h4);
    wr(1, 32'h8);
    rd(1, d); chk("R5 other bit", 64'(d), 64'h4);
    wr(0, 32'h0);
    chk("R6 masked", 64'(irq_o), 64'h0);
    rd(1, d); chk("R6 status kept", 64'(d), 64'h4);
    wr(0, 32'h1 << 3);
    chk("R6 unmasked", 64'(irq_o), 64'h1);
    wr(1, 32'h4);
    rd(1, d); chk("R5 cleared", 64'(d), 64'h0);
    chk("R6 irq off", 64'(irq_o), 64'h0);

    // R9 / R7: shadow transfer on the clear
    cnt_drv = '1;
    wr(0, 32'h0);
    wr(2, 32'd10); wr(3, 32'd0);
    wr(0, SHADOW | 32'h3);
    wr(2, 32'd20);
    rd(2, d); chk("R9 live held", 64'(d), 64'd10);
    cnt_drv = 64'd20;
    @(negedge clk);
    chk("R9 old value used", 64'(match_o), 64'h0);
    cnt_drv = 64'd10;
    #0.5;
    chk("R7 clear", 64'(cnt_clr_o), 64'h1);
    @(negedge clk);
    chk("R3 ch0 pulse", 64'(match_o), 64'h1);
    rd(2, d); chk("R9 transferred", 64'(d), 64'd20);

    // R7: bit 0 clear means no clear request
    cnt_drv = '1;
    wr(0, 32'h2);
    cnt_drv = 64'd20;
    #0.5;
    chk("R7 disarmed", 64'(cnt_clr_o), 64'h0);

    // R10: cyclic timebase, P = 40, INC = 4
    cnt_drv = '1;
    wr(0, 32'h0);
    wr(2, 32'd36); wr(3, 32'd0);
    wr(0, 32'h3);
    run = 1'b1;
    begin
      int last = -1;
      int pulses = 0;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (cnt_clr_o) begin
          if (last >= 0) chk("R10 period", 64'(c - last), 64'd10);
          last = c;
          pulses++;
        end
      end
      chk("R10 pulse count", 64'(pulses >= 5), 64'h1);
    end
    run = 1'b0;

    finish_run();
  end
endmodule